// File: doc/BRIEF.md
# Ethernet Transmit Frame Builder

This block turns an outgoing frame, offered one byte at a time on an AXI-Stream style input, into the complete byte sequence that a PHY-side byte interface expects. The input frame carries only the destination address and the EtherType/payload. The builder adds everything else: the preamble and start-of-frame delimiter in front, its own station address after the destination, zero padding up to the minimum size, and the CRC-32 frame check sequence at the end.

Because these added bytes take cycles of their own, the input is throttled. `s_tready` is high only while a byte from the source is actually being forwarded. Between frames it stays low for a fixed idle period, so all per-frame state is cleared before the next frame is taken. The station address is a static configuration input.

The controller is one state machine with these states:
- ST_IDLE waits for `s_tvalid`.
- ST_PRE sends the preamble.
- ST_SFD sends the delimiter.
- ST_DST forwards the six destination bytes.
- ST_SRC inserts the six station-address bytes.
- ST_BODY forwards the input until `s_tlast`.
- ST_PAD emits zero bytes.
- ST_FCS sends the four check bytes.
- ST_GAP holds the line idle before the builder returns to ST_IDLE.

Its transitions are:
- IDLE to PRE when valid data is waiting.
- PRE to SFD after seven bytes.
- SFD to DST after one byte.
- DST to SRC after six bytes.
- SRC to BODY after six bytes.
- BODY to PAD or to FCS on the last input byte. The choice depends on whether 60 bytes have been sent.
- PAD to FCS once the 60th byte goes out.
- FCS to GAP after four bytes.
- GAP to IDLE after twelve cycles.

Top module: `eth_tx_framer`

## Requirements
- R1: While reset is asserted, and in the cycle after it is applied even mid-frame, `tx_en` and `s_tready` are 0.
- R2: Each frame on `tx_data` begins with seven bytes of 0x55 followed by one byte of 0xD5, and `tx_en` is high for all of them.
- R3: The six destination bytes are forwarded unchanged. They are followed by the six bytes of `src_mac`, most significant byte (`src_mac[47:40]`) first. `s_tready` is low during the inserted bytes, so the 7th input byte is taken exactly 7 cycles after the 6th.
- R4: The input bytes from the 7th one (EtherType onward) through the byte marked `s_tlast` follow the inserted address unchanged and in order.
- R5: When destination, address and input body together are shorter than 60 bytes, 0x00 bytes are appended until 60 bytes precede the check sequence. Every emitted frame after the delimiter is therefore at least 64 bytes.
- R6: The last four bytes are the CRC-32 over all bytes after the delimiter, including padding. It uses reflected polynomial 0xEDB88320, initial value 0xFFFFFFFF and final inversion, and is sent least significant byte first.
- R7: `s_tready` is low in every cycle that does not forward an input byte. It is low in the cycle after the `s_tlast` byte is taken and while idle with no frame. At least 12 cycles with `tx_en` low separate consecutive frames.
- R8: A frame whose bytes before the check sequence already number 60 or more gets no padding. The emitted length after the delimiter is exactly the input length plus 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_mac | input | 48 | Local station address, static during operation |
| s_tdata | input | 8 | Input frame byte |
| s_tvalid | input | 1 | Input byte valid |
| s_tlast | input | 1 | Marks the final input byte of a frame |
| s_tready | output | 1 | Builder takes the input byte this cycle |
| tx_data | output | 8 | Byte toward the PHY |
| tx_en | output | 1 | `tx_data` carries a frame byte |

## Verification
The assertions take for granted that the source keeps `s_tvalid` high from the first byte of a frame through its `s_tlast` byte, with no bubbles. They also assume that every frame carries at least eight bytes (destination plus EtherType), so `s_tlast` never falls within the destination field. The bench respects this by driving each frame as one unbroken burst, with input lengths of eight bytes or more. It offers the next frame as soon as the previous last byte is taken, which is what makes the inter-frame idle check meaningful.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE,
        ST_SFD,
        ST_DST,
        ST_SRC,
        ST_BODY,
        ST_PAD,
        ST_FCS,
        ST_GAP
    } tx_state_e;

    // One byte of the reflected CRC-32 update, least significant bit first.
    function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            r = (r[0] ^ d[i]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/eth_tx_counter.sv
module eth_tx_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (clr) q <= '0;
        else if (inc) q <= q + 1'b1;
    end
endmodule

// File: rtl/eth_tx_crc.sv
module eth_tx_crc (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] crc_q
);
    import eth_tx_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     crc_q <= 32'hFFFF_FFFF;
        else if (init)  crc_q <= 32'hFFFF_FFFF;
        else if (en)    crc_q <= crc32_step(crc_q, din);
    end
endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer #(
    parameter int PRE_LEN   = 7,
    parameter int MIN_BODY  = 60,
    parameter int GAP_LEN   = 12,
    parameter int MAX_FRAME = 2047
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [47:0] src_mac,
    input  logic [7:0]  s_tdata,
    input  logic        s_tvalid,
    input  logic        s_tlast,
    output logic        s_tready,
    output logic [7:0]  tx_data,
    output logic        tx_en
);
    import eth_tx_pkg::*;

    localparam int MAC_BYTES = 6;
    localparam int FCS_BYTES = 4;
    localparam int IDX_MAX   = (PRE_LEN > GAP_LEN) ?
                               ((PRE_LEN > MAC_BYTES) ? PRE_LEN : MAC_BYTES) :
                               ((GAP_LEN > MAC_BYTES) ? GAP_LEN : MAC_BYTES);
    localparam int IDX_W     = $clog2(IDX_MAX + 1);
    localparam int LEN_W     = $clog2(MAX_FRAME + 1);

    tx_state_e st, nxt;

    logic [IDX_W-1:0] idx;
    logic [LEN_W-1:0] len_q;
    logic [31:0]      crc_q;
    logic [47:0]      mac_sh;
    logic [31:0]      fcs_sh;
    logic             out_en;
    logic [7:0]       out_b;
    logic             frame_byte;
    logic             body_full;

    assign mac_sh    = src_mac << {idx, 3'b000};
    assign fcs_sh    = ~crc_q >> {idx, 3'b000};
    assign body_full = (int'(len_q) + 1) >= MIN_BODY;

    eth_tx_counter #(.W(IDX_W)) u_idx (
        .clk(clk), .rst_n(rst_n), .clr(nxt != st), .inc(1'b1), .q(idx)
    );

    eth_tx_counter #(.W(LEN_W)) u_len (
        .clk(clk), .rst_n(rst_n), .clr(st == ST_IDLE), .inc(frame_byte), .q(len_q)
    );

    eth_tx_crc u_crc (
        .clk(clk), .rst_n(rst_n), .init(st == ST_IDLE), .en(frame_byte),
        .din(out_b), .crc_q(crc_q)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // Next state and per-cycle outputs.
    always_comb begin
        nxt        = st;
        s_tready   = 1'b0;
        out_en     = 1'b0;
        out_b      = 8'h00;
        frame_byte = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (s_tvalid) nxt = ST_PRE;
            end
            ST_PRE: begin
                out_en = 1'b1;
                out_b  = 8'h55;
                if (idx == IDX_W'(PRE_LEN - 1)) nxt = ST_SFD;
            end
            ST_SFD: begin
                out_en = 1'b1;
                out_b  = 8'hD5;
                nxt    = ST_DST;
            end
            ST_DST: begin
                s_tready   = 1'b1;
                out_en     = 1'b1;
                out_b      = s_tdata;
                frame_byte = 1'b1;
                if (idx == IDX_W'(MAC_BYTES - 1)) nxt = ST_SRC;
            end
            ST_SRC: begin
                out_en     = 1'b1;
                out_b      = mac_sh[47:40];
                frame_byte = 1'b1;
                if (idx == IDX_W'(MAC_BYTES - 1)) nxt = ST_BODY;
            end
            ST_BODY: begin
                s_tready   = 1'b1;
                out_en     = 1'b1;
                out_b      = s_tdata;
                frame_byte = 1'b1;
                if (s_tlast) nxt = body_full ? ST_FCS : ST_PAD;
            end
            ST_PAD: begin
                out_en     = 1'b1;
                frame_byte = 1'b1;
                if (body_full) nxt = ST_FCS;
            end
            ST_FCS: begin
                out_en = 1'b1;
                out_b  = fcs_sh[7:0];
                if (idx == IDX_W'(FCS_BYTES - 1)) nxt = ST_GAP;
            end
            ST_GAP: begin
                if (idx == IDX_W'(GAP_LEN - 1)) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Registered byte interface toward the PHY.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_en   <= 1'b0;
            tx_data <= 8'h00;
        end else begin
            tx_en   <= out_en;
            tx_data <= out_b;
        end
    end
endmodule

// File: rtl/eth_tx_chk.sv
module eth_tx_chk #(
    parameter int PRE_LEN  = 7,
    parameter int GAP_LEN  = 12,
    parameter int MIN_BODY = 60
) (
    input logic       clk,
    input logic       rst_n,
    input logic       s_tvalid,
    input logic       s_tlast,
    input logic       s_tready,
    input logic       tx_en,
    input logic [7:0] tx_data
);
    localparam int MIN_RUN = PRE_LEN + 1 + MIN_BODY + 4;

    logic [15:0] on_run;
    logic [15:0] off_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            on_run  <= '0;
            off_run <= 16'(GAP_LEN);
        end else if (tx_en) begin
            on_run  <= (on_run == 16'hFFFF) ? on_run : on_run + 1'b1;
            off_run <= '0;
        end else begin
            on_run  <= '0;
            off_run <= (off_run == 16'hFFFF) ? off_run : off_run + 1'b1;
        end
    end

    // R7: an input byte is only taken while a frame is on the line
    assert_ready_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_tready |-> tx_en);

    // R7: no byte is taken in the cycle after the last one
    assert_stall_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_tready && s_tvalid && s_tlast) |=> !s_tready);

    // R2: every frame opens with a preamble byte
    assert_preamble_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> (tx_data == 8'h55));

    // R7: idle spacing between frames
    assert_gap_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> (off_run >= 16'(GAP_LEN)));

    // R5: minimum emitted length
    assert_min_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_en) |-> (on_run >= 16'(MIN_RUN)));
endmodule

bind eth_tx_framer eth_tx_chk #(
    .PRE_LEN(PRE_LEN), .GAP_LEN(GAP_LEN), .MIN_BODY(MIN_BODY)
) u_chk (
    .clk(clk), .rst_n(rst_n), .s_tvalid(s_tvalid), .s_tlast(s_tlast),
    .s_tready(s_tready), .tx_en(tx_en), .tx_data(tx_data)
);

// File: tb/sim_eth_tx_framer.sv
module sim_eth_tx_framer;

    localparam int NV = 6;
    // input length (destination + EtherType + payload), expected length after delimiter
    localparam int VEC_IN [NV]  = '{8, 53, 54, 55, 100, 9};
    localparam int VEC_OUT[NV]  = '{64, 64, 64, 65, 110, 64};
    localparam logic [47:0] MAC_A = 48'h02_1A_2B_3C_4D_5E;
    localparam logic [47:0] MAC_B = 48'hAC_DE_48_00_11_22;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [47:0] src_mac = MAC_A;
    logic [7:0]  s_tdata = 8'h00;
    logic        s_tvalid = 1'b0;
    logic        s_tlast = 1'b0;
    logic        s_tready;
    logic [7:0]  tx_data;
    logic        tx_en;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit ended = 0;

    logic [7:0] mon [0:7][0:255];
    int mon_len [0:7];
    int mon_gap [0:7];
    int fcount = 0;
    int idle = 1000;
    logic prev_en = 1'b0;

    logic [7:0] ex [0:255];
    int ex_n;

    eth_tx_framer u0 (
        .clk(clk), .rst_n(rst_n), .src_mac(src_mac), .s_tdata(s_tdata),
        .s_tvalid(s_tvalid), .s_tlast(s_tlast), .s_tready(s_tready),
        .tx_data(tx_data), .tx_en(tx_en)
    );

    always #5 clk = ~clk;

    task automatic finish_run;
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not complete (actual cycles %0d, expected < 100000)", cyc);
            finish_run();
        end
    end

    // Capture emitted frames away from the active edge.
    always @(negedge clk) begin
        if (fcount < 8) begin
            if (tx_en) begin
                if (!prev_en) begin
                    mon_gap[fcount] = idle;
                    mon_len[fcount] = 0;
                end
                if (mon_len[fcount] < 256) mon[fcount][mon_len[fcount]] = tx_data;
                mon_len[fcount]++;
                idle = 0;
            end else begin
                if (prev_en) fcount++;
                idle++;
            end
        end
        prev_en = tx_en;
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int i, input int seed);
        return 8'((i * 37 + seed * 11 + 5) & 255);
    endfunction

    task automatic send_frame(input int len, input int seed);
        int t5 = 0;
        int t6 = 0;
        for (int i = 0; i < len; i++) begin
            s_tdata  = pat(i, seed);
            s_tvalid = 1'b1;
            s_tlast  = (i == len - 1);
            while (!s_tready) @(negedge clk);
            if (i == 5) t5 = cyc;
            if (i == 6) t6 = cyc;
            @(negedge clk);
        end
        s_tvalid = 1'b0;
        s_tlast  = 1'b0;
        check(!s_tready, "R7", "ready after last byte", int'(s_tready), 0);
        check(t6 - t5 == 7, "R3", "cycles between 6th and 7th accepted byte", t6 - t5, 7);
    endtask

    task automatic build_exp(input int len, input int seed, input logic [47:0] mac);
        logic [31:0] c;
        ex_n = 0;
        for (int i = 0; i < 6; i++) begin ex[ex_n] = pat(i, seed); ex_n++; end
        for (int j = 0; j < 6; j++) begin ex[ex_n] = mac[47 - 8*j -: 8]; ex_n++; end
        for (int i = 6; i < len; i++) begin ex[ex_n] = pat(i, seed); ex_n++; end
        while (ex_n < 60) begin ex[ex_n] = 8'h00; ex_n++; end
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < ex_n; i++) begin
            c = c ^ {24'h0, ex[i]};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        c = ~c;
        for (int j = 0; j < 4; j++) begin ex[ex_n] = c[8*j +: 8]; ex_n++; end
    endtask

    task automatic cmp_range(input int k, input int lo, input int hi, input string req, input string what);
        int bad_at = -1;
        for (int i = lo; i < hi; i++) begin
            if (bad_at < 0 && mon[k][8 + i] !== ex[i]) bad_at = i;
        end
        if (bad_at < 0) check(1'b1, req, what, 0, 0);
        else check(1'b0, req, what, int'(mon[k][8 + bad_at]), int'(ex[bad_at]));
    endtask

    task automatic verify(input int k, input int len, input int seed, input logic [47:0] mac,
                          input int exp_total, input bit gap_chk);
        int pre_bad = 0;
        build_exp(len, seed, mac);
        check(mon_len[k] == 8 + exp_total, (len + 6 >= 60) ? "R8" : "R5",
              "emitted byte count incl. preamble", mon_len[k], 8 + exp_total);
        for (int i = 0; i < 7; i++) if (mon[k][i] !== 8'h55) pre_bad++;
        if (mon[k][7] !== 8'hD5) pre_bad++;
        check(pre_bad == 0, "R2", "preamble/delimiter bytes wrong", pre_bad, 0);
        cmp_range(k, 0, 6, "R3", "destination byte");
        cmp_range(k, 6, 12, "R3", "inserted source address byte");
        cmp_range(k, 12, len + 6, "R4", "body byte");
        if (len + 6 < 60) cmp_range(k, len + 6, 60, "R5", "pad byte");
        cmp_range(k, ex_n - 4, ex_n, "R6", "check sequence byte");
        if (gap_chk) check(mon_gap[k] >= 12, "R7", "idle cycles before frame", mon_gap[k], 12);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!tx_en && !s_tready, "R1", "outputs during reset", int'({tx_en, s_tready}), 0);
        rst_n = 1'b1;
        begin
            int hits = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (s_tready || tx_en) hits++;
            end
            check(hits == 0, "R7", "activity while idle without valid", hits, 0);
        end

        // Table of vectors, back to back.
        for (int k = 0; k < NV; k++) send_frame(VEC_IN[k], k);
        wait (fcount == NV);
        for (int k = 0; k < NV; k++) verify(k, VEC_IN[k], k, MAC_A, VEC_OUT[k], k > 0);

        // Directed: different station address, unpadded frame (R3, R8).
        repeat (20) @(negedge clk);
        src_mac = MAC_B;
        send_frame(61, 9);
        wait (fcount == NV + 1);
        verify(NV, 61, 9, MAC_B, 71, 1'b1);

        // Directed: reset in the middle of a frame (R1).
        s_tdata = 8'hA5; s_tvalid = 1'b1; s_tlast = 1'b0;
        while (!tx_en) @(negedge clk);
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        s_tvalid = 1'b0;
        @(negedge clk);
        check(!tx_en && !s_tready, "R1", "outputs after mid-frame reset", int'({tx_en, s_tready}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!tx_en && !s_tready, "R1", "outputs after reset release", int'({tx_en, s_tready}), 0);

        finish_run();
    end

endmodule